// File: doc/BRIEF.md
# Line Error Counter Bank

This block keeps four performance-monitoring counts for a T1/E1 receive path. The counts are CRC-6 errors on extended-superframe links, bipolar violations that are not part of a B8ZS substitution, frame alignment words with at least one bit error, and far-end E-bit errors. The framer and the line decoder qualify each event upstream. Each event arrives as a one-cycle strobe, and the bank adds one to the matching counter.

A byte-wide register port gives read and write access to every counter. Counters wider than a byte take two addresses. A low-byte write goes into a staging byte, and the counter loads only when its high byte is written. Reading a low byte captures the upper bits so that a later high-byte read matches it. Every counter has two interrupt sources: a single-event source and a wrap-to-zero source. Each source has a sticky status bit and a mask bit. The block drives one active-high interrupt line.

Top module: `line_err_cnt_bank`

## Requirements
- R1: After reset, every counter, both mask words and both status words read 0x00, and irq_o is low.
- R2: A strobe on crc_err_i, bpv_err_i, fas_err_i or ebit_err_i adds exactly one to its own counter (16, 16, 8 and 10 bits wide) and leaves the other counters unchanged. Map: CRC 0x00/0x01, BPV 0x02/0x03, FAS 0x04, E-bit 0x06/0x07, low byte at the lower address.
- R3: A counter at all ones that receives an event wraps to zero and sets its bit in the overflow status word at 0x13.
- R4: Every counted event toggles the counter LSB and sets the counter's bit in the single-event status word at 0x12. The bits are CRC 6, BPV 3, FAS 1 and E-bit 0, and the mask words use the same positions.
- R5: A write to a low-byte address only stages the byte and leaves the counter unchanged. The following high-byte write loads {high, staged} into the counter. For the 10-bit counter only bits 1:0 of the high byte are used. A load sets no status bit.
- R6: If an event strobe arrives in the same cycle as a loading write to its counter, the event is dropped. The written value is loaded and no status bit is set.
- R7: A write to 0x04 loads the 8-bit frame-alignment counter directly.
- R8: Status bits stay set until their word is read. The read returns the value held before the read and clears the word. An event in the same cycle as the read stays set.
- R9: irq_o is high exactly when a status bit and its mask bit (single mask 0x10, overflow mask 0x11) are both set. Mask words read back as written.
- R10: Reading a low byte captures the counter's upper bits. The next high-byte read returns the captured value even if the counter has changed in between. Read data appears on rdata_o one cycle after rd_i.
- R11: Writes to unmapped addresses change nothing, and reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crc_err_i | input | 1 | CRC-6 error strobe |
| bpv_err_i | input | 1 | Bipolar violation strobe |
| fas_err_i | input | 1 | Errored alignment word strobe |
| ebit_err_i | input | 1 | E-bit error strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
The counters are driven in several ways: all four strobes at once, one source at a time, and back-to-back strobes across the all-ones boundary of each width. These separate independent per-counter increments from crosstalk between counters, and a correct wrap from a stuck or saturating count. Split writes are interleaved with reads and with events. This distinguishes a staged low byte from an immediate partial load and checks that the upper-byte capture holds while the count moves. Collisions are tested next: an event together with a load, and an event together with a status read. These separate the intended priority (the load wins, a new event is kept) from the reverse. Finally, masks are toggled while status is pending, which shows that irq_o follows the masked status.

// File: rtl/lec_pkg.sv
package lec_pkg;
  localparam int NCH = 4;
  localparam int AW  = 5;
  localparam int DW  = 8;

  // channel order: CRC, BPV, FAS, E-bit
  localparam logic [AW-1:0] LO_ADDR [NCH] = '{5'h00, 5'h02, 5'h04, 5'h06};
  localparam logic [AW-1:0] HI_ADDR [NCH] = '{5'h01, 5'h03, 5'h04, 5'h07};
  localparam int            ST_BIT  [NCH] = '{6, 3, 1, 0};

  localparam logic [AW-1:0] A_SGL_MSK = 5'h10;
  localparam logic [AW-1:0] A_OVF_MSK = 5'h11;
  localparam logic [AW-1:0] A_SGL_ST  = 5'h12;
  localparam logic [AW-1:0] A_OVF_ST  = 5'h13;
endpackage

// File: rtl/lec_counter.sv
module lec_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             event_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] count_o,
  output logic             step_o,
  output logic             wrap_o
);
  logic [WIDTH-1:0] cnt_q;

  // a load takes priority and swallows a coincident event
  assign step_o  = event_i & ~load_i;
  assign wrap_o  = step_o & (&cnt_q);
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (event_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lec_irq_regs.sv
module lec_irq_regs
  import lec_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NCH-1:0] step_i,
  input  logic [NCH-1:0] wrap_i,
  output logic [DW-1:0] sgl_st_o,
  output logic [DW-1:0] ovf_st_o,
  output logic [DW-1:0] sgl_msk_o,
  output logic [DW-1:0] ovf_msk_o,
  output logic          irq_o
);
  logic [DW-1:0] sgl_set, ovf_set;
  logic [DW-1:0] sgl_st_q, ovf_st_q, sgl_msk_q, ovf_msk_q;
  logic          sgl_clr, ovf_clr;

  always_comb begin
    sgl_set = '0;
    ovf_set = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      sgl_set[ST_BIT[ch]] = sgl_set[ST_BIT[ch]] | step_i[ch];
      ovf_set[ST_BIT[ch]] = ovf_set[ST_BIT[ch]] | wrap_i[ch];
    end
  end

  assign sgl_clr = rd_i && (addr_i == A_SGL_ST);
  assign ovf_clr = rd_i && (addr_i == A_OVF_ST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sgl_st_q  <= '0;
      ovf_st_q  <= '0;
      sgl_msk_q <= '0;
      ovf_msk_q <= '0;
    end else begin
      // new events survive a clearing read
      sgl_st_q <= (sgl_clr ? '0 : sgl_st_q) | sgl_set;
      ovf_st_q <= (ovf_clr ? '0 : ovf_st_q) | ovf_set;
      if (wr_i && addr_i == A_SGL_MSK) sgl_msk_q <= wdata_i;
      if (wr_i && addr_i == A_OVF_MSK) ovf_msk_q <= wdata_i;
    end
  end

  assign sgl_st_o  = sgl_st_q;
  assign ovf_st_o  = ovf_st_q;
  assign sgl_msk_o = sgl_msk_q;
  assign ovf_msk_o = ovf_msk_q;
  assign irq_o     = |(sgl_st_q & sgl_msk_q) | |(ovf_st_q & ovf_msk_q);
endmodule

// File: rtl/line_err_cnt_bank.sv
module line_err_cnt_bank
  import lec_pkg::*;
#(
  parameter int CRC_W  = 16,
  parameter int BPV_W  = 16,
  parameter int FAS_W  = 8,
  parameter int EBIT_W = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          crc_err_i,
  input  logic          bpv_err_i,
  input  logic          fas_err_i,
  input  logic          ebit_err_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  localparam int CW = 2 * DW;
  localparam int CH_W [NCH] = '{CRC_W, BPV_W, FAS_W, EBIT_W};

  logic [NCH-1:0] ev, ld, step, wrap;
  logic [CW-1:0]  cnt_pad [NCH];
  logic [DW-1:0]  stage_q, hold_q, hold_d, rdata_q, rd_val;
  logic [DW-1:0]  sgl_st, ovf_st, sgl_msk, ovf_msk;
  logic           stage_we;

  assign ev = {ebit_err_i, fas_err_i, bpv_err_i, crc_err_i};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int W = CH_W[g];
    logic [W-1:0] lval, cnt;

    if (W > DW) begin : g_two
      assign lval = {wdata_i[W-DW-1:0], stage_q};
    end else begin : g_one
      assign lval = wdata_i[W-1:0];
    end

    assign ld[g] = wr_i && (addr_i == HI_ADDR[g]);

    lec_counter #(.WIDTH(W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .event_i    (ev[g]),
      .load_i     (ld[g]),
      .load_val_i (lval),
      .count_o    (cnt),
      .step_o     (step[g]),
      .wrap_o     (wrap[g])
    );

    assign cnt_pad[g] = CW'(cnt);
  end

  always_comb begin
    stage_we = 1'b0;
    for (int ch = 0; ch < NCH; ch++)
      if (CH_W[ch] > DW && addr_i == LO_ADDR[ch]) stage_we = wr_i;
  end

  always_comb begin
    rd_val = '0;
    hold_d = hold_q;
    for (int ch = 0; ch < NCH; ch++) begin
      if (addr_i == LO_ADDR[ch]) begin
        rd_val = cnt_pad[ch][DW-1:0];
        if (CH_W[ch] > DW) hold_d = cnt_pad[ch][CW-1:DW];
      end
      if (CH_W[ch] > DW && addr_i == HI_ADDR[ch]) rd_val = hold_q;
    end
    case (addr_i)
      A_SGL_MSK: rd_val = sgl_msk;
      A_OVF_MSK: rd_val = ovf_msk;
      A_SGL_ST:  rd_val = sgl_st;
      A_OVF_ST:  rd_val = ovf_st;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      hold_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (stage_we) stage_q <= wdata_i;
      if (rd_i) begin
        rdata_q <= rd_val;
        hold_q  <= hold_d;
      end
    end
  end

  lec_irq_regs u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .step_i    (step),
    .wrap_i    (wrap),
    .sgl_st_o  (sgl_st),
    .ovf_st_o  (ovf_st),
    .sgl_msk_o (sgl_msk),
    .ovf_msk_o (ovf_msk),
    .irq_o     (irq_o)
  );

  assign rdata_o = rdata_q;
endmodule

// File: rtl/line_err_cnt_bank_chk.sv
module line_err_cnt_bank_chk
  import lec_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          crc_err_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          irq_o,
  input logic [15:0]   crc_cnt,
  input logic [15:0]   fas_cnt,
  input logic [DW-1:0] sgl_st,
  input logic [DW-1:0] ovf_st,
  input logic [DW-1:0] sgl_msk,
  input logic [DW-1:0] ovf_msk
);
  logic crc_ld;
  assign crc_ld = wr_i && (addr_i == HI_ADDR[0]);

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_i && !crc_ld |=> crc_cnt == 16'($past(crc_cnt) + 16'd1));

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !crc_err_i && !crc_ld |=> $stable(crc_cnt));

  assert_wrap_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_i && !crc_ld && crc_cnt == 16'hFFFF |=> ovf_st[6] && crc_cnt == 16'h0000);

  assert_stage_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == LO_ADDR[0] && !crc_err_i |=> $stable(crc_cnt));

  assert_load_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == LO_ADDR[2] |=> fas_cnt[7:0] == $past(wdata_i));

  assert_status_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sgl_st[6] && !(rd_i && addr_i == A_SGL_ST) |=> sgl_st[6]);

  assert_irq_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sgl_msk == '0 && ovf_msk == '0 |-> !irq_o);
endmodule

bind line_err_cnt_bank line_err_cnt_bank_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .crc_err_i (crc_err_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .irq_o     (irq_o),
  .crc_cnt   (cnt_pad[0]),
  .fas_cnt   (cnt_pad[2]),
  .sgl_st    (sgl_st),
  .ovf_st    (ovf_st),
  .sgl_msk   (sgl_msk),
  .ovf_msk   (ovf_msk)
);

// File: tb/line_err_cnt_bank_test.sv
module line_err_cnt_bank_test;
  localparam logic [1:0] K_IDLE = 2'd0, K_WR = 2'd1, K_RD = 2'd2;

  typedef struct packed {
    logic [1:0] k;
    logic [4:0] a;
    logic [7:0] d;
    logic [3:0] e;   // {ebit, fas, bpv, crc}
    logic [7:0] x;
    logic [3:0] r;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{K_RD,   5'h00, 8'h00, 4'b0000, 8'h00, 4'd1},  // R1
    '{K_RD,   5'h12, 8'h00, 4'b0000, 8'h00, 4'd1},  // R1
    '{K_IDLE, 5'h00, 8'h00, 4'b1111, 8'h00, 4'd0},
    '{K_IDLE, 5'h00, 8'h00, 4'b0001, 8'h00, 4'd0},
    '{K_RD,   5'h00, 8'h00, 4'b0000, 8'h02, 4'd2},  // R2
    '{K_RD,   5'h01, 8'h00, 4'b0000, 8'h00, 4'd2},
    '{K_RD,   5'h02, 8'h00, 4'b0000, 8'h01, 4'd2},
    '{K_RD,   5'h04, 8'h00, 4'b0000, 8'h01, 4'd2},
    '{K_RD,   5'h06, 8'h00, 4'b0000, 8'h01, 4'd2},
    '{K_RD,   5'h12, 8'h00, 4'b0000, 8'h4B, 4'd4},  // R4 bits 6,3,1,0
    '{K_RD,   5'h12, 8'h00, 4'b0000, 8'h00, 4'd8},  // R8 cleared
    '{K_WR,   5'h00, 8'hFE, 4'b0000, 8'h00, 4'd0},
    '{K_RD,   5'h00, 8'h00, 4'b0000, 8'h02, 4'd5},  // R5 staged only
    '{K_WR,   5'h01, 8'hFF, 4'b0000, 8'h00, 4'd0},
    '{K_RD,   5'h00, 8'h00, 4'b0000, 8'hFE, 4'd5},
    '{K_RD,   5'h01, 8'h00, 4'b0000, 8'hFF, 4'd5},
    '{K_IDLE, 5'h00, 8'h00, 4'b0001, 8'h00, 4'd0},
    '{K_IDLE, 5'h00, 8'h00, 4'b0001, 8'h00, 4'd0},
    '{K_RD,   5'h13, 8'h00, 4'b0000, 8'h40, 4'd3},  // R3 16-bit wrap
    '{K_RD,   5'h00, 8'h00, 4'b0000, 8'h00, 4'd3},
    '{K_WR,   5'h04, 8'hFF, 4'b0100, 8'h00, 4'd0},
    '{K_RD,   5'h04, 8'h00, 4'b0000, 8'hFF, 4'd7},  // R7 and R6
    '{K_RD,   5'h12, 8'h00, 4'b0000, 8'h40, 4'd6},  // R6 no FAS bit
    '{K_IDLE, 5'h00, 8'h00, 4'b0100, 8'h00, 4'd0},
    '{K_RD,   5'h13, 8'h00, 4'b0000, 8'h02, 4'd3},  // R3 8-bit wrap
    '{K_WR,   5'h06, 8'hFF, 4'b0000, 8'h00, 4'd0},
    '{K_WR,   5'h07, 8'hFF, 4'b0000, 8'h00, 4'd0},
    '{K_IDLE, 5'h00, 8'h00, 4'b1000, 8'h00, 4'd0},
    '{K_RD,   5'h13, 8'h00, 4'b0000, 8'h01, 4'd3},  // R3 10-bit wrap
    '{K_RD,   5'h06, 8'h00, 4'b0000, 8'h00, 4'd3},
    '{K_WR,   5'h10, 8'h4B, 4'b0000, 8'h00, 4'd0},
    '{K_WR,   5'h11, 8'h4B, 4'b0000, 8'h00, 4'd0},
    '{K_RD,   5'h12, 8'h00, 4'b0000, 8'h03, 4'd4},
    '{K_RD,   5'h11, 8'h00, 4'b0000, 8'h4B, 4'd9}   // R9 readback
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       crc_err_i = 1'b0, bpv_err_i = 1'b0, fas_err_i = 1'b0, ebit_err_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic       irq_o;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  line_err_cnt_bank uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .crc_err_i(crc_err_i), .bpv_err_i(bpv_err_i),
    .fas_err_i(fas_err_i), .ebit_err_i(ebit_err_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .wr_i(wr_i), .rd_i(rd_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic step(input logic [1:0] k, input logic [4:0] a,
                      input logic [7:0] d, input logic [3:0] e);
    wr_i = (k == K_WR);
    rd_i = (k == K_RD);
    addr_i = a;
    wdata_i = d;
    {ebit_err_i, fas_err_i, bpv_err_i, crc_err_i} = e;
    @(negedge clk);
    wr_i = 1'b0; rd_i = 1'b0;
    {ebit_err_i, fas_err_i, bpv_err_i, crc_err_i} = '0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
    step(K_RD, a, 8'h00, 4'b0000);
    chk(tag, rdata_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk("R1 irq after reset", {7'd0, irq_o}, 8'h00);
    chk("R1 rdata after reset", rdata_o, 8'h00);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].k, VEC[i].a, VEC[i].d, VEC[i].e);
      if (VEC[i].k == K_RD)
        chk($sformatf("R%0d vector %0d", VEC[i].r, i), rdata_o, VEC[i].x);
    end

    // R10: high byte comes from the capture made at the low-byte read
    step(K_WR, 5'h02, 8'hFF, 4'b0000);
    step(K_WR, 5'h03, 8'h12, 4'b0000);
    rd_chk("R10 bpv low", 5'h02, 8'hFF);
    step(K_IDLE, 5'h00, 8'h00, 4'b0010);
    chk("R9 irq on masked single", {7'd0, irq_o}, 8'h01);
    rd_chk("R10 bpv high held", 5'h03, 8'h12);
    rd_chk("R10 bpv low fresh", 5'h02, 8'h00);
    rd_chk("R10 bpv high fresh", 5'h03, 8'h13);
    rd_chk("R4 bpv status bit", 5'h12, 8'h08);
    chk("R9 irq drops after clear", {7'd0, irq_o}, 8'h00);

    // R6: event on the loading high-byte write is dropped
    step(K_WR, 5'h02, 8'h34, 4'b0000);
    step(K_WR, 5'h03, 8'h56, 4'b0010);
    rd_chk("R6 bpv low", 5'h02, 8'h34);
    rd_chk("R6 bpv high", 5'h03, 8'h56);
    rd_chk("R6 no status", 5'h12, 8'h00);

    // R9: mask gates the line
    step(K_WR, 5'h10, 8'h00, 4'b0000);
    step(K_IDLE, 5'h00, 8'h00, 4'b0001);
    chk("R9 masked off", {7'd0, irq_o}, 8'h00);
    step(K_WR, 5'h10, 8'h40, 4'b0000);
    chk("R9 unmask raises", {7'd0, irq_o}, 8'h01);
    rd_chk("R8 crc status", 5'h12, 8'h40);
    chk("R9 irq after read", {7'd0, irq_o}, 8'h00);

    // R8: event coinciding with the clearing read is kept
    step(K_RD, 5'h12, 8'h00, 4'b0100);
    chk("R8 read returns old", rdata_o, 8'h00);
    chk("R9 unmasked bit quiet", {7'd0, irq_o}, 8'h00);
    rd_chk("R8 same-cycle event kept", 5'h12, 8'h02);

    // R11: unmapped address
    step(K_WR, 5'h1F, 8'hAA, 4'b0000);
    rd_chk("R11 unmapped read", 5'h1F, 8'h00);
    rd_chk("R11 mask untouched", 5'h10, 8'h40);

    // R1: reset in mid-run
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    chk("R1 irq after re-reset", {7'd0, irq_o}, 8'h00);
    rd_chk("R1 fas cleared", 5'h04, 8'h00);
    rd_chk("R1 mask cleared", 5'h10, 8'h00);
    rd_chk("R1 ebit high cleared", 5'h07, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule